// File: doc/BRIEF.md
# Leading/Trailing Zero Counter

This unit counts a run of consecutive zero bits in a 64-bit operand. The run is measured either from the most significant end (leading zeros) or from the least significant end (trailing zeros). A second select narrows the examined operand to its low 32 bits. The count comes back zero-extended to a full 64-bit result, so an execution datapath can write it straight to a destination register.

The unit is purely combinational. It has no clock, no reset and no handshake. The result settles within one clock period of any change on the operand or the selects.

An all-zero examined operand returns the examined width: 64 in doubleword mode, 32 in word mode. No separate invalid flag is produced.

Both directions share a single priority encoder. For a trailing count, the operand is bit-reversed before it reaches the encoder. In word mode, the low word is moved to the top of the encoder input and the count is capped at 32.

Top module: `zero_count_unit`

## Requirements
- R1: With word select 0 and direction select 0, the result equals the number of zero bits above the highest set bit of the 64-bit operand.
- R2: With word select 0 and direction select 1, the result equals the bit index of the lowest set bit of the 64-bit operand.
- R3: With word select 0, an all-zero operand gives 64 (0x40) in both directions.
- R4: With word select 1, operand bits 63..32 have no effect on the result.
- R5: With word select 1 and direction select 0, the result equals 31 minus the index of the highest set bit in bits 31..0.
- R6: With word select 1 and direction select 1, the result equals the index of the lowest set bit in bits 31..0.
- R7: With word select 1, a zero low word gives 32 (0x20) in both directions, even when upper bits are set. A word-mode result never exceeds 32.
- R8: The count sits in result bits 6..0. Result bits 63..7 are always zero.
- R9: The result follows an input change without any clock edge, well within one 5 ns period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 64 | Value whose zero run is counted |
| from_lsb_i | input | 1 | 0 = count from bit 63 (or bit 31) downward, 1 = count from bit 0 upward |
| word_mode_i | input | 1 | 1 = examine only bits 31..0 |
| count_o | output | 64 | Zero-extended zero count |

## Verification
The two selects can change in the same cycle as the operand, which makes the reversal path and the word-mode cap apply together. The trailing-count word case is the most exposed, because it reverses only the low word and then caps the result.

The bench provokes this case with walking single-one patterns at every position under all four select combinations. It also applies random operands that have a forced boundary bit and random garbage in the upper half, with both selects redrawn on every vector. Each result is judged against a plain bit-scanning reference loop in the bench. The cap is checked by requiring exactly 32 whenever the low word is zero.

// File: rtl/zc_pkg.sv
package zc_pkg;
  localparam int unsigned ZC_DATA_W  = 64;
  localparam int unsigned ZC_WORD_W  = 32;
  localparam int unsigned ZC_GROUP_W = 8;
  localparam int unsigned ZC_CNT_W   = $clog2(ZC_DATA_W) + 1;

  typedef enum logic [1:0] {
    ZC_DW_LEAD  = 2'b00,
    ZC_DW_TRAIL = 2'b01,
    ZC_WD_LEAD  = 2'b10,
    ZC_WD_TRAIL = 2'b11
  } zc_mode_e;
endpackage

// File: rtl/zc_prep.sv
module zc_prep #(
  parameter int unsigned W  = 64,
  parameter int unsigned WW = 32
) (
  input  logic [W-1:0] op_i,
  input  logic         lsb_i,
  input  logic         word_i,
  output logic [W-1:0] vec_o
);
  import zc_pkg::*;

  localparam int unsigned PAD_W = W - WW;

  logic [W-1:0]  rev_full;
  logic [WW-1:0] low_word;
  logic [WW-1:0] rev_low;
  zc_mode_e      mode;

  assign low_word = op_i[WW-1:0];

  for (genvar i = 0; i < W; i++) begin : g_rev_full
    assign rev_full[i] = op_i[W-1-i];
  end

  for (genvar j = 0; j < WW; j++) begin : g_rev_low
    assign rev_low[j] = low_word[WW-1-j];
  end

  assign mode = zc_mode_e'({word_i, lsb_i});

  always_comb begin
    unique case (mode)
      ZC_DW_LEAD:  vec_o = op_i;
      ZC_DW_TRAIL: vec_o = rev_full;
      ZC_WD_LEAD:  vec_o = {low_word, {PAD_W{1'b0}}};
      default:     vec_o = {rev_low, {PAD_W{1'b0}}};
    endcase
  end

  // R2
  always_comb begin
    if (!word_i && lsb_i)
      trail_bit0_map_chk: assert (vec_o[W-1] == op_i[0]);
  end
endmodule

// File: rtl/zc_group_enc.sv
module zc_group_enc #(
  parameter int unsigned G  = 8,
  parameter int unsigned GW = $clog2(G) + 1
) (
  input  logic [G-1:0]  grp_i,
  output logic [GW-1:0] lz_o,
  output logic          nz_o
);
  always_comb begin
    lz_o = GW'(G);
    for (int i = 0; i < G; i++) begin
      if (grp_i[i]) lz_o = GW'(G - 1 - i);
    end
  end

  assign nz_o = |grp_i;

  // R1
  always_comb begin
    group_zero_len_chk: assert (nz_o || (lz_o == GW'(G)));
  end
endmodule

// File: rtl/zc_prio_enc.sv
module zc_prio_enc #(
  parameter int unsigned W  = 64,
  parameter int unsigned G  = 8,
  parameter int unsigned CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  localparam int unsigned NG = W / G;
  localparam int unsigned GW = $clog2(G) + 1;

  logic [GW-1:0] lz [NG];
  logic [NG-1:0] nz;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    zc_group_enc #(.G(G), .GW(GW)) u_grp (
      .grp_i (vec_i[W-1-g*G -: G]),
      .lz_o  (lz[g]),
      .nz_o  (nz[g])
    );
  end

  always_comb begin
    cnt_o = CW'(W);
    for (int g = NG - 1; g >= 0; g--) begin
      if (nz[g]) cnt_o = CW'(g * G) + CW'(lz[g]);
    end
  end

  // R1
  always_comb begin
    if (vec_i != '0)
      lead_hit_chk: assert (vec_i[W-1-cnt_o] == 1'b1);
  end
endmodule

// File: rtl/zc_format.sv
module zc_format #(
  parameter int unsigned W  = 64,
  parameter int unsigned WW = 32,
  parameter int unsigned CW = $clog2(W) + 1
) (
  input  logic [CW-1:0] raw_i,
  input  logic          word_i,
  output logic [W-1:0]  res_o
);
  logic [CW-1:0] capped;

  always_comb begin
    capped = raw_i;
    if (word_i && (raw_i > CW'(WW))) capped = CW'(WW);
  end

  assign res_o = {{(W-CW){1'b0}}, capped};
endmodule

// File: rtl/zero_count_unit.sv
module zero_count_unit #(
  parameter int unsigned DATA_W  = zc_pkg::ZC_DATA_W,
  parameter int unsigned WORD_W  = zc_pkg::ZC_WORD_W,
  parameter int unsigned GROUP_W = zc_pkg::ZC_GROUP_W
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic              from_lsb_i,
  input  logic              word_mode_i,
  output logic [DATA_W-1:0] count_o
);
  localparam int unsigned CW = $clog2(DATA_W) + 1;

  logic [DATA_W-1:0] enc_vec;
  logic [CW-1:0]     raw_cnt;

  zc_prep #(.W(DATA_W), .WW(WORD_W)) u_prep (
    .op_i   (operand_i),
    .lsb_i  (from_lsb_i),
    .word_i (word_mode_i),
    .vec_o  (enc_vec)
  );

  zc_prio_enc #(.W(DATA_W), .G(GROUP_W), .CW(CW)) u_enc (
    .vec_i (enc_vec),
    .cnt_o (raw_cnt)
  );

  zc_format #(.W(DATA_W), .WW(WORD_W), .CW(CW)) u_fmt (
    .raw_i  (raw_cnt),
    .word_i (word_mode_i),
    .res_o  (count_o)
  );

  always_comb begin
    // R8
    upper_zero_chk: assert (count_o[DATA_W-1:CW] == '0);
    // R7
    if (word_mode_i)
      word_cap_chk: assert (count_o <= DATA_W'(WORD_W));
    // R7
    if (word_mode_i && (operand_i[WORD_W-1:0] == '0))
      word_zero_chk: assert (count_o == DATA_W'(WORD_W));
    // R3
    if (!word_mode_i && (operand_i == '0))
      dword_zero_chk: assert (count_o == DATA_W'(DATA_W));
    // R2
    if (!word_mode_i && from_lsb_i && operand_i[0])
      trail_zero_len_chk: assert (count_o == '0);
  end
endmodule

// File: tb/tb_zero_count_unit.sv
module tb_zero_count_unit;
  logic        clk;
  logic [63:0] op;
  logic        lsb;
  logic        word;
  logic [63:0] res;
  int          checks;
  int          failures;
  int          cycles;

  zero_count_unit dut (
    .operand_i   (op),
    .from_lsb_i  (lsb),
    .word_mode_i (word),
    .count_o     (res)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [63:0] ref_cnt(logic [63:0] v, logic l, logic w);
    int n;
    int c;
    bit found;
    n = w ? 32 : 64;
    c = n;
    found = 0;
    if (!l) begin
      for (int i = n - 1; i >= 0; i--)
        if (!found && v[i]) begin c = n - 1 - i; found = 1; end
    end else begin
      for (int i = 0; i < n; i++)
        if (!found && v[i]) begin c = i; found = 1; end
    end
    return 64'(c);
  endfunction

  function automatic string req_of(logic l, logic w, logic [63:0] v);
    if (!w && v == '0) return "R3";
    if (w && v[31:0] == '0) return "R7";
    if (w) return l ? "R6" : "R5";
    return l ? "R2" : "R1";
  endfunction

  task automatic check(string tag, logic [63:0] exp);
    checks++;
    if (res !== exp) begin
      failures++;
      $display("FAIL %s op=%h lsb=%0b word=%0b got=%h exp=%h", tag, op, lsb, word, res, exp);
    end
    if (res[63:7] !== '0) begin
      failures++;
      $display("FAIL R8 upper bits got=%h exp=0", res);
    end
  endtask

  task automatic apply(logic [63:0] v, logic l, logic w);
    @(posedge clk);
    op = v; lsb = l; word = w;
    @(negedge clk);
    check(req_of(l, w, v), ref_cnt(v, l, w));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] r;
    logic [63:0] base;
    checks = 0; failures = 0; cycles = 0;
    op = '0; lsb = 1'b0; word = 1'b0;
    void'($urandom(32'd20240611));
    @(negedge clk);
    check("R3 reset-state", 64'd64);

    // R3 and R7 all-zero cases
    apply(64'h0, 1'b0, 1'b0);
    apply(64'h0, 1'b1, 1'b0);
    apply(64'h0, 1'b0, 1'b1);
    apply(64'h0, 1'b1, 1'b1);
    apply(64'hFFFF_FFFF_0000_0000, 1'b0, 1'b1);
    apply(64'h8000_0000_0000_0000, 1'b1, 1'b1);

    // R1 R2 R5 R6 walking single one, all four select combinations
    for (int b = 0; b < 64; b++)
      for (int m = 0; m < 4; m++)
        apply(64'h1 << b, m[0], m[1]);

    // R4 upper bits ignored in word mode
    for (int k = 0; k < 40; k++) begin
      base = {32'h0, $urandom()};
      base[k % 32] = 1'b1;
      for (int m = 0; m < 2; m++) begin
        apply(base, m[0], 1'b1);
        r = res;
        apply({$urandom(), base[31:0]}, m[0], 1'b1);
        checks++;
        if (res !== r) begin
          failures++;
          $display("FAIL R4 upper bits changed result got=%h exp=%h", res, r);
        end
      end
    end

    // random operands with a forced boundary bit, selects redrawn each time
    for (int k = 0; k < 3000; k++) begin
      r = {$urandom(), $urandom()};
      case (k % 4)
        0: r[63] = 1'b1;
        1: r[0] = 1'b1;
        2: r[31] = 1'b1;
        default: r = r >> ($urandom() % 64);
      endcase
      apply(r, 1'($urandom()), 1'($urandom()));
    end

    // R9 result follows a change without a clock edge
    @(negedge clk);
    op = 64'h0000_0100_0000_0000; lsb = 1'b0; word = 1'b0;
    #1;
    check("R9 mid-cycle", 64'd23);
    lsb = 1'b1; word = 1'b1;
    #1;
    check("R9 mid-cycle", 64'd32);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule